// File: doc/BRIEF.md
# Interleaved Address Reconstruction Unit

This block rebuilds an upper-level memory address from an address local to one slice of a two-way interleaved pair. The slice address space has two parts. The lower part is interleaved: one address bit was removed when the upper-level address was split between the two slices. The upper part belongs only to the larger slice and was only offset.

For the interleaved part, the unit opens a gap at the interleave position by moving the upper bits up one place. It then fills the gap with an XOR hash. The hash is computed over the provisional address and seeded with the index of the slice the address came from. For the offset part, the unit adds the small-slice size back.

A request is presented with a valid strobe. The result appears, registered, one cycle later. Requests may arrive on every cycle.

Top module: `addr_rebuild`

## Requirements
- R1: While reset is asserted and after its release, until the first request, outValid is 0 and outAddr is 0.
- R2: outValid is 1 in exactly the cycles that follow a cycle with inValid at 1. outAddr then holds the result for that request.
- R3: When sliceAddr is greater than or equal to smallSize, including equality, outAddr equals sliceAddr + smallSize modulo 2^64.
- R4: When sliceAddr is less than smallSize, the interleave position is p = 6 + posSel, where posSel is a 3-bit value giving p from 6 to 13. Bits of sliceAddr below p keep their place in outAddr. Bits from p upward move up by one place, and sliceAddr bit 63 is dropped.
- R5: In that zone, outAddr bit p equals hashBase XOR the parity of the provisional address over bits 6 to 19. The provisional address is the R4 address with a zero at p. Bit k of the address takes part when hashMask bit k-6 is 1, or when k equals p.
- R6: With hashMask all zero, outAddr bit p of an interleaved result equals hashBase.
- R7: The result decodes back to the original request. For the interleaved zone, removing bit p of outAddr and closing the gap gives sliceAddr, when sliceAddr bit 63 is 0. In that zone, the parity over bits 6 to 19 of outAddr, selected by hashMask with bit p forced on, equals hashBase. For the other zone, outAddr - smallSize gives sliceAddr.
- R8: In a cycle with inValid at 0, outAddr keeps its previous value, whatever the other inputs do.
- R9: Requests on consecutive cycles each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A request is presented this cycle |
| sliceAddr | input | 64 | Address local to the slice |
| smallSize | input | 64 | Size of the smaller slice, which is the end of the interleaved zone |
| posSel | input | 3 | Interleave position minus 6 |
| hashMask | input | 14 | Hash select; bit i covers address bit i+6 |
| hashBase | input | 1 | Index of the slice the address came from; seeds the hash |
| outValid | output | 1 | outAddr holds a new result |
| outAddr | output | 64 | Reconstructed upper-level address |

## Verification
Two things can fall in the same cycle. The unit captures a new request in the same cycle that it presents the result of the previous one. The bench provokes this by streaming requests with inValid held high, and changing every input right after each result is sampled. Each result is judged against a bench model and is also decoded back to its request. Gaps with inValid low and garbage on the data inputs then show that the held result is not disturbed. A second same-cycle case is a request whose address sits exactly at smallSize, where the choice of zone and the arithmetic meet. The bench covers it with directed stimulus on both sides of the boundary.

// File: rtl/addr_rebuild_pkg.sv
package addr_rebuild_pkg;

  typedef struct packed {
    logic capture;
  } rebuildStrobe_t;

endpackage

// File: rtl/rebuild_control.sv
module rebuild_control
  import addr_rebuild_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output rebuildStrobe_t strobe,
  output logic           outValid
);

  always_comb begin
    strobe.capture = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/rebuild_datapath.sv
module rebuild_datapath
  import addr_rebuild_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SEL_W    = 3,
  parameter int POS_BASE = 6,
  parameter int HASH_LO  = 6,
  parameter int HASH_HI  = 19
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rebuildStrobe_t               strobe,
  input  logic [ADDR_W-1:0]            sliceAddr,
  input  logic [ADDR_W-1:0]            smallSize,
  input  logic [SEL_W-1:0]             posSel,
  input  logic [HASH_HI-HASH_LO:0]     hashMask,
  input  logic                         hashBase,
  output logic [ADDR_W-1:0]            outAddr
);

  localparam int NUM_POS = 1 << SEL_W;
  localparam int SH_W    = $clog2(ADDR_W);

  logic [ADDR_W-1:0] provArr [NUM_POS];
  logic [ADDR_W-1:0] provisional;
  logic [SH_W-1:0]   posIdx;
  logic [ADDR_W-1:0] posBit;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] maskWide;
  logic [ADDR_W-1:0] selMask;
  logic [ADDR_W-1:0] selected;
  logic              hashBit;
  logic              highZone;
  logic [ADDR_W-1:0] nextAddr;

  // One gap-opening candidate per selectable position.
  for (genvar k = 0; k < NUM_POS; k++) begin : g_pos
    localparam int P = POS_BASE + k;
    assign provArr[k] = {sliceAddr[ADDR_W-2:P], 1'b0, sliceAddr[P-1:0]};
  end

  always_comb begin
    posIdx      = SH_W'(POS_BASE) + SH_W'(posSel);
    posBit      = ADDR_W'(1) << posIdx;
    lowMask     = posBit - ADDR_W'(1);
    provisional = provArr[posSel];
    maskWide    = ADDR_W'(hashMask) << HASH_LO;
    selMask     = maskWide | posBit;
    selected    = provisional & selMask;
    hashBit     = hashBase ^ (^selected[HASH_HI:HASH_LO]);
    highZone    = sliceAddr >= smallSize;
    if (highZone) nextAddr = sliceAddr + smallSize;
    else          nextAddr = provisional | (ADDR_W'(hashBit) << posIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               outAddr <= '0;
    else if (strobe.capture) outAddr <= nextAddr;
  end

  // R3
  offset_zone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && highZone) |=>
      ((outAddr - $past(smallSize)) == $past(sliceAddr)));

  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !highZone) |=>
      (((outAddr ^ $past(sliceAddr)) & $past(lowMask)) == '0));

  // R4
  high_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !highZone) |=>
      ((outAddr >> ($past(posIdx) + SH_W'(1))) ==
       (($past(sliceAddr) << 1) >> ($past(posIdx) + SH_W'(1)))));

  // R7
  id_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !highZone) |=>
      ((^(outAddr[HASH_HI:HASH_LO] & $past(selMask[HASH_HI:HASH_LO]))) ==
       $past(hashBase)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outAddr));

endmodule

// File: rtl/addr_rebuild.sv
module addr_rebuild
  import addr_rebuild_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SEL_W    = 3,
  parameter int POS_BASE = 6,
  parameter int HASH_LO  = 6,
  parameter int HASH_HI  = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [ADDR_W-1:0]        sliceAddr,
  input  logic [ADDR_W-1:0]        smallSize,
  input  logic [SEL_W-1:0]         posSel,
  input  logic [HASH_HI-HASH_LO:0] hashMask,
  input  logic                     hashBase,
  output logic                     outValid,
  output logic [ADDR_W-1:0]        outAddr
);

  rebuildStrobe_t strobe;

  rebuild_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rebuild_datapath #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .POS_BASE (POS_BASE),
    .HASH_LO  (HASH_LO),
    .HASH_HI  (HASH_HI)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sliceAddr (sliceAddr),
    .smallSize (smallSize),
    .posSel    (posSel),
    .hashMask  (hashMask),
    .hashBase  (hashBase),
    .outAddr   (outAddr)
  );

endmodule

// File: tb/test_addr_rebuild.sv
module test_addr_rebuild;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] sliceAddr = '0;
  logic [63:0] smallSize = '0;
  logic [2:0]  posSel = '0;
  logic [13:0] hashMask = '0;
  logic        hashBase = 1'b0;
  logic        outValid;
  logic [63:0] outAddr;

  int checks = 0;
  int errors = 0;
  logic [63:0] lastOut = '0;

  always #5 clk = ~clk;

  addr_rebuild i_addr_rebuild (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sliceAddr(sliceAddr),
    .smallSize(smallSize), .posSel(posSel), .hashMask(hashMask),
    .hashBase(hashBase), .outValid(outValid), .outAddr(outAddr)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] s,
                                        input logic [2:0] sel, input logic [13:0] m,
                                        input logic b);
    int p;
    logic [63:0] prov;
    logic h;
    p = 6 + int'(sel);
    if (a >= s) return a + s;
    prov = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < p) prov[i] = a[i];
      else if (i > p) prov[i] = a[i-1];
    end
    h = b;
    for (int i = 6; i < 20; i++) if (m[i-6] || i == p) h = h ^ prov[i];
    prov[p] = h;
    return prov;
  endfunction

  function automatic logic [63:0] squeeze(input logic [63:0] x, input int p);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 63; i++) r[i] = (i < p) ? x[i] : x[i+1];
    return r;
  endfunction

  function automatic logic decodeId(input logic [63:0] x, input logic [13:0] m, input int p);
    logic h;
    h = 1'b0;
    for (int i = 6; i < 20; i++) if (m[i-6] || i == p) h = h ^ x[i];
    return h;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] s,
                       input logic [2:0] sel, input logic [13:0] m, input logic b);
    logic [63:0] exp;
    int p;
    exp = model(a, s, sel, m, b);
    p = 6 + int'(sel);
    inValid = 1'b1; sliceAddr = a; smallSize = s; posSel = sel; hashMask = m; hashBase = b;
    @(negedge clk);
    check64("R2 valid", {63'd0, outValid}, 64'd1);
    check64(tag, outAddr, exp);
    if (a >= s) begin
      check64("R7 offset decode", outAddr - s, a);
    end else begin
      if (!a[63]) check64("R7 squeeze", squeeze(outAddr, p), a);
      check64("R7 id", {63'd0, decodeId(outAddr, m, p)}, {63'd0, b});
    end
    lastOut = outAddr;
  endtask

  task automatic idle();
    inValid = 1'b0;
    sliceAddr = {$urandom, $urandom}; smallSize = {$urandom, $urandom};
    posSel = 3'($urandom); hashMask = 14'($urandom); hashBase = 1'($urandom);
    @(negedge clk);
    check64("R2 no valid", {63'd0, outValid}, 64'd0);
    check64("R8 hold", outAddr, lastOut);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] s;
    logic [63:0] a;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check64("R1 valid in reset", {63'd0, outValid}, 64'd0);
    check64("R1 addr in reset", outAddr, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check64("R1 valid after reset", {63'd0, outValid}, 64'd0);
    check64("R1 addr after reset", outAddr, 64'd0);

    apply("R3 equality", 64'd1000, 64'd1000, 3'd0, 14'h0, 1'b0);
    check64("R3 literal", outAddr, 64'd2000);
    apply("R6 zero mask", 64'd0, 64'd1, 3'd0, 14'h0, 1'b1);
    check64("R6 literal", outAddr, 64'd64);
    apply("R6 below boundary", 64'd999, 64'd1000, 3'd0, 14'h0, 1'b1);
    check64("R6 literal2", outAddr, 64'h7E7);
    apply("R5 full mask top pos", 64'h0000_0000_00AB_CDEF, 64'h0000_0001_0000_0000, 3'd7, 14'h3FFF, 1'b0);
    apply("R5 full mask base1", 64'h0000_0000_0001_2345, 64'h0000_0000_1000_0000, 3'd3, 14'h3FFF, 1'b1);
    apply("R4 bit63 dropped", 64'h8000_0000_0000_0041, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 14'h0155, 1'b0);
    apply("R3 wrap", 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 3'd2, 14'h0, 1'b1);
    idle();
    idle();
    apply("R9 after idle", 64'd12345, 64'd99999, 3'd5, 14'h2A0F, 1'b1);

    for (int n = 0; n < 600; n++) begin
      s = {$urandom, $urandom} >> ($urandom % 8);
      if (s == 0) s = 64'd1;
      a = {$urandom, $urandom};
      if ($urandom % 2 == 0) a = a % s;
      else if (a < s) a = s + 64'(a % 64'd4096);
      if (n % 9 == 4) a = s;
      if (n % 9 == 5) a = s - 64'd1;
      apply(a >= s ? "R9 R3 stream" : "R9 R4 R5 stream", a, s, 3'($urandom),
            (n % 5 == 0) ? 14'h0 : 14'($urandom), 1'($urandom));
      if (n % 7 == 6) idle();
    end
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule